// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block is the storage core of a stack-organised floating-point register file. It holds eight 64-bit words in physical slots and addresses them relative to a three-bit top pointer that wraps around, so stack slot ST(i) always names physical slot (top + i) mod 8. A one-bit tag per physical slot records whether the slot holds a live value. Arithmetic, rounding and number formats live elsewhere: this block only stores, addresses and checks words.

One command is accepted per clock when `cmd_valid` is high. The result of a command (returned data, its tag, and either of the two fault strobes) appears on the registered outputs in the following cycle, and the top pointer and tags take their new values on the same edge. A command that faults changes no slot, no tag and no pointer. Two exemptions apply to the fault rules: examining a slot never reports an empty fault, and copying ST(0) into another slot never reports a full fault.

Top module: `fpstk_core`

## Requirements
- R1: After reset every tag is empty (0), the top pointer is 0, every slot holds zero, and `rd_valid`, `fault_empty` and `fault_full` are low.
- R2: Push (opcode 0) first moves top to (top-1) mod 8, then stores `cmd_wdata` there and marks that tag full; if the slot at (top-1) mod 8 is already full the command raises `fault_full` instead.
- R3: Pop (opcode 1) returns the word at ST(0) with `rd_tag`=1, marks that tag empty and then moves top to (top+1) mod 8; if ST(0) is empty it raises `fault_empty` instead.
- R4: Read (opcode 2) of ST(i), with i on `cmd_idx`, returns the word in physical slot (top+i) mod 8 with `rd_tag`=1, and raises `fault_empty` if that slot is empty.
- R5: Write (opcode 3) stores `cmd_wdata` into an empty ST(i) and marks it full; writing to a full ST(i) raises `fault_full`.
- R6: Read-modify-write (opcode 4) of a full ST(i) returns the old word and stores `cmd_wdata` in its place; on an empty ST(i) it raises `fault_empty`.
- R7: Examine (opcode 5) returns the word and the tag of ST(i) whatever the tag state and never raises a fault.
- R8: Copy (opcode 6) stores the word of ST(0) into ST(i) and marks ST(i) full, even when ST(i) is already full, without any full fault; an empty ST(0) raises `fault_empty`.
- R9: Free (opcode 7) marks ST(i) empty, raises no fault, returns no data and leaves top unchanged.
- R10: A fault is a single-cycle strobe with `rd_valid` low, the two faults never coincide, and slots, tags and top are left unchanged.
- R11: Results appear on the cycle after the command; a cycle with `cmd_valid` low yields no data, no fault and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode (0 push .. 7 free) |
| cmd_idx | input | 3 | Stack-relative slot i for ST(i) commands |
| cmd_wdata | input | 64 | Word for push, write and read-modify-write |
| rd_valid | output | 1 | Returned word valid this cycle |
| rd_data | output | 64 | Returned word |
| rd_tag | output | 1 | Tag of the returned slot |
| fault_empty | output | 1 | Empty-slot access strobe |
| fault_full | output | 1 | Full-slot overwrite strobe |
| top_ptr | output | 3 | Current top pointer |

## Verification
The bench goes after pointer wrap in both directions: nine pushes from top 0 must wrap to 7 and fault on the ninth, and a design that tested the tag before moving the pointer would fault one push early or overwrite ST(0). It checks the two exemptions directly, examining empty slots and copying over full ones; a design that applied the general fault rules there would strobe a fault and leave the destination stale. It follows every fault with examines of the slots involved, so a design that wrote or moved the pointer while faulting would show wrong data or a shifted top. A long randomised command stream, compared every cycle with a behavioural model, catches a wrong (top+i) mapping as mismatched data on reads.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_RMW   = 3'd4,
    OP_EXAM  = 3'd5,
    OP_COPY  = 3'd6,
    OP_FREE  = 3'd7
  } fpstk_op_e;

endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int DATA_W = 64,
  parameter int PW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     ra_addr,
  input  logic [PW-1:0]     rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << PW;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en && (wr_addr == PW'(g))) begin
        word_q <= wr_data;
      end
    end
    assign words[g] = word_q;
  end

  assign ra_data = words[ra_addr];
  assign rb_data = words[rb_addr];

endmodule

// File: rtl/fpstk_tagfile.sv
module fpstk_tagfile #(
  parameter int PW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [PW-1:0]       addr,
  output logic [(1<<PW)-1:0]  tags
);
  localparam int DEPTH = 1 << PW;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    logic live_q;
    logic hit;
    assign hit = (addr == PW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q <= 1'b0;
      end else if (set_en && hit) begin
        live_q <= 1'b1;
      end else if (clr_en && hit) begin
        live_q <= 1'b0;
      end
    end
    assign tags[g] = live_q;
  end

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PW     = 3
) (
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [PW-1:0]       cmd_idx,
  input  logic [DATA_W-1:0]   cmd_wdata,
  input  logic [PW-1:0]       top,
  input  logic [(1<<PW)-1:0]  tags,
  input  logic [DATA_W-1:0]   slot_word,
  input  logic [DATA_W-1:0]   top_word,
  output logic [PW-1:0]       slot_addr,
  output logic [PW-1:0]       top_addr,
  output logic                wr_en,
  output logic [PW-1:0]       wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                tag_set,
  output logic                tag_clr,
  output logic [PW-1:0]       tag_addr,
  output logic                top_ld,
  output logic [PW-1:0]       top_nxt,
  output logic                ret_valid,
  output logic [DATA_W-1:0]   ret_data,
  output logic                ret_tag,
  output logic                ev_empty,
  output logic                ev_full
);
  // Stack-relative to physical slot: ST(i) -> (top + i) mod depth.
  function automatic logic [PW-1:0] st_slot(input logic [PW-1:0] t,
                                            input logic [PW-1:0] i);
    return t + i;
  endfunction

  function automatic logic [PW-1:0] below_top(input logic [PW-1:0] t);
    return t - 1'b1;
  endfunction

  function automatic logic [PW-1:0] above_top(input logic [PW-1:0] t);
    return t + 1'b1;
  endfunction

  fpstk_op_e      op_e;
  logic [PW-1:0]  push_slot;
  logic           slot_live;
  logic           top_live;
  logic           push_live;

  assign op_e      = fpstk_op_e'(cmd_op);
  assign slot_addr = st_slot(top, cmd_idx);
  assign top_addr  = top;
  assign push_slot = below_top(top);
  assign slot_live = tags[slot_addr];
  assign top_live  = tags[top];
  assign push_live = tags[push_slot];

  always_comb begin
    wr_en     = 1'b0;
    wr_addr   = slot_addr;
    wr_data   = cmd_wdata;
    tag_set   = 1'b0;
    tag_clr   = 1'b0;
    tag_addr  = slot_addr;
    top_ld    = 1'b0;
    top_nxt   = top;
    ret_valid = 1'b0;
    ret_data  = slot_word;
    ret_tag   = 1'b0;
    ev_empty  = 1'b0;
    ev_full   = 1'b0;
    if (cmd_valid) begin
      unique case (op_e)
        OP_PUSH: begin
          if (push_live) begin
            ev_full = 1'b1;
          end else begin
            wr_en    = 1'b1;
            wr_addr  = push_slot;
            tag_set  = 1'b1;
            tag_addr = push_slot;
            top_ld   = 1'b1;
            top_nxt  = push_slot;
          end
        end
        OP_POP: begin
          if (!top_live) begin
            ev_empty = 1'b1;
          end else begin
            ret_valid = 1'b1;
            ret_data  = top_word;
            ret_tag   = 1'b1;
            tag_clr   = 1'b1;
            tag_addr  = top;
            top_ld    = 1'b1;
            top_nxt   = above_top(top);
          end
        end
        OP_READ: begin
          if (!slot_live) begin
            ev_empty = 1'b1;
          end else begin
            ret_valid = 1'b1;
            ret_tag   = 1'b1;
          end
        end
        OP_WRITE: begin
          if (slot_live) begin
            ev_full = 1'b1;
          end else begin
            wr_en   = 1'b1;
            tag_set = 1'b1;
          end
        end
        OP_RMW: begin
          if (!slot_live) begin
            ev_empty = 1'b1;
          end else begin
            ret_valid = 1'b1;
            ret_tag   = 1'b1;
            wr_en     = 1'b1;
            tag_set   = 1'b1;
          end
        end
        OP_EXAM: begin
          ret_valid = 1'b1;
          ret_tag   = slot_live;
        end
        OP_COPY: begin
          if (!top_live) begin
            ev_empty = 1'b1;
          end else begin
            wr_en   = 1'b1;
            wr_data = top_word;
            tag_set = 1'b1;
          end
        end
        OP_FREE: begin
          tag_clr = 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/fpstk_core.sv
module fpstk_core #(
  parameter int DATA_W = 64,
  parameter int PW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PW-1:0]     cmd_idx,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              fault_empty,
  output logic              fault_full,
  output logic [PW-1:0]     top_ptr
);
  localparam int DEPTH = 1 << PW;

  logic [PW-1:0]     top_q;
  logic [DEPTH-1:0]  tags;
  logic [PW-1:0]     slot_addr;
  logic [PW-1:0]     top_addr;
  logic [DATA_W-1:0] slot_word;
  logic [DATA_W-1:0] top_word;
  logic              wr_en;
  logic [PW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              tag_set;
  logic              tag_clr;
  logic [PW-1:0]     tag_addr;
  logic              top_ld;
  logic [PW-1:0]     top_nxt;
  logic              ret_valid;
  logic [DATA_W-1:0] ret_data;
  logic              ret_tag;
  logic              ev_empty;
  logic              ev_full;

  fpstk_ctrl #(.DATA_W(DATA_W), .PW(PW)) u_ctrl (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_wdata (cmd_wdata),
    .top       (top_q),
    .tags      (tags),
    .slot_word (slot_word),
    .top_word  (top_word),
    .slot_addr (slot_addr),
    .top_addr  (top_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tag_set   (tag_set),
    .tag_clr   (tag_clr),
    .tag_addr  (tag_addr),
    .top_ld    (top_ld),
    .top_nxt   (top_nxt),
    .ret_valid (ret_valid),
    .ret_data  (ret_data),
    .ret_tag   (ret_tag),
    .ev_empty  (ev_empty),
    .ev_full   (ev_full)
  );

  fpstk_regfile #(.DATA_W(DATA_W), .PW(PW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ra_addr (slot_addr),
    .rb_addr (top_addr),
    .ra_data (slot_word),
    .rb_data (top_word)
  );

  fpstk_tagfile #(.PW(PW)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (tag_set),
    .clr_en (tag_clr),
    .addr   (tag_addr),
    .tags   (tags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q       <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_tag      <= 1'b0;
      fault_empty <= 1'b0;
      fault_full  <= 1'b0;
    end else begin
      if (top_ld) top_q <= top_nxt;
      rd_valid    <= ret_valid;
      fault_empty <= ev_empty;
      fault_full  <= ev_full;
      if (ret_valid) begin
        rd_data <= ret_data;
        rd_tag  <= ret_tag;
      end
    end
  end

  assign top_ptr = top_q;

endmodule

// File: rtl/fpstk_core_chk.sv
module fpstk_core_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          rd_valid,
  input logic          fault_empty,
  input logic          fault_full,
  input logic [PW-1:0] top_ptr,
  input logic          ev_empty,
  input logic          ev_full
);
  p_single_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_empty && fault_full));

  p_fault_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_empty || fault_full) |-> !rd_valid);

  p_fault_holds_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_empty || fault_full) |-> (top_ptr == $past(top_ptr)));

  p_event_to_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_empty || ev_full) |=> (fault_empty || fault_full));

  p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=>
      (fault_full || top_ptr == PW'($past(top_ptr) - 1'b1)));

  p_pop_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=>
      (fault_empty || top_ptr == PW'($past(top_ptr) + 1'b1)));

  p_exam_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (rd_valid && !fault_empty && !fault_full));

  p_copy_no_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=> !fault_full);

  p_free_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7) |=>
      (!fault_empty && !fault_full && !rd_valid && top_ptr == $past(top_ptr)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!rd_valid && !fault_empty && !fault_full && $stable(top_ptr)));

endmodule

bind fpstk_core fpstk_core_chk #(.PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .rd_valid    (rd_valid),
  .fault_empty (fault_empty),
  .fault_full  (fault_full),
  .top_ptr     (top_ptr),
  .ev_empty    (ev_empty),
  .ev_full     (ev_full)
);

// File: tb/fpstk_core_test.sv
`timescale 1ns/1ps
module fpstk_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [63:0] cmd_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        rd_tag;
  logic        fault_empty;
  logic        fault_full;
  logic [2:0]  top_ptr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [63:0] m_word [8];
  bit          m_live [8];
  int          m_top;

  always #2.5 clk = ~clk;

  fpstk_core uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_tag(rd_tag), .fault_empty(fault_empty),
    .fault_full(fault_full), .top_ptr(top_ptr)
  );

  task automatic cmp(input string what, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input bit ev, input logic [63:0] ed,
                           input bit et, input bit efe, input bit eff);
    cmp("rd_valid", req, 64'(rd_valid), 64'(ev));
    cmp("fault_empty", req, 64'(fault_empty), 64'(efe));
    cmp("fault_full", req, 64'(fault_full), 64'(eff));
    cmp("top_ptr", req, 64'(top_ptr), 64'(m_top));
    if (ev) begin
      cmp("rd_data", req, rd_data, ed);
      cmp("rd_tag", req, 64'(rd_tag), 64'(et));
    end
  endtask

  // Issue one command at a falling edge, update the model, compare one cycle later.
  task automatic step(input int op, input int idx, input logic [63:0] d, input string req);
    bit ev = 0, et = 0, efe = 0, eff = 0;
    logic [63:0] ed = '0;
    int p = (m_top + idx) % 8;
    int t;
    cmd_valid = 1'b1;
    cmd_op    = op[2:0];
    cmd_idx   = idx[2:0];
    cmd_wdata = d;
    case (op)
      0: begin
        t = (m_top + 7) % 8;
        if (m_live[t]) eff = 1;
        else begin m_word[t] = d; m_live[t] = 1; m_top = t; end
      end
      1: begin
        if (!m_live[m_top]) efe = 1;
        else begin
          ev = 1; ed = m_word[m_top]; et = 1;
          m_live[m_top] = 0; m_top = (m_top + 1) % 8;
        end
      end
      2: begin
        if (!m_live[p]) efe = 1;
        else begin ev = 1; ed = m_word[p]; et = 1; end
      end
      3: begin
        if (m_live[p]) eff = 1;
        else begin m_word[p] = d; m_live[p] = 1; end
      end
      4: begin
        if (!m_live[p]) efe = 1;
        else begin ev = 1; ed = m_word[p]; et = 1; m_word[p] = d; end
      end
      5: begin ev = 1; ed = m_word[p]; et = m_live[p]; end
      6: begin
        if (!m_live[m_top]) efe = 1;
        else begin m_word[p] = m_word[m_top]; m_live[p] = 1; end
      end
      default: m_live[p] = 0;
    endcase
    @(negedge clk);
    check_out(req, ev, ed, et, efe, eff);
  endtask

  task automatic idle(input string req);
    cmd_valid = 1'b0;
    cmd_op    = 3'd4;
    cmd_idx   = 3'd2;
    cmd_wdata = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    check_out(req, 0, '0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    string reqs [8] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9"};
    for (int k = 0; k < 8; k++) begin m_word[k] = '0; m_live[k] = 0; end
    m_top = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_out("R1", 0, '0, 0, 0, 0);
    for (int k = 0; k < 8; k++) step(5, k, '0, "R1");
    // empty faults on a fresh stack
    step(1, 0, '0, "R3");
    step(2, 3, '0, "R4");
    step(4, 1, 64'h11, "R6");
    step(6, 2, '0, "R8");
    // nine pushes: wrap from 0 to 7 and overflow on the ninth
    for (int k = 0; k < 9; k++) step(0, 0, 64'hA5A5_0000_0000_0100 + 64'(k), "R2");
    step(5, 0, '0, "R10");
    for (int k = 0; k < 8; k++) step(2, k, '0, "R4");
    step(3, 2, 64'hBAD, "R5");
    step(5, 2, '0, "R10");
    step(7, 2, '0, "R9");
    step(5, 2, '0, "R9");
    step(3, 2, 64'h0123_4567_89AB_CDEF, "R5");
    step(2, 2, '0, "R5");
    step(4, 1, 64'hFEED_0000_0000_0004, "R6");
    step(2, 1, '0, "R6");
    step(6, 5, '0, "R8");
    step(5, 5, '0, "R8");
    idle("R11");
    for (int k = 0; k < 8; k++) step(1, 0, '0, "R3");
    step(1, 0, '0, "R3");
    step(5, 3, '0, "R7");
    step(4, 3, 64'h77, "R6");
    step(6, 4, '0, "R8");
    step(5, 4, '0, "R10");
    idle("R11");
    // randomised stream against the model
    for (int n = 0; n < 3000; n++) begin
      int op  = $urandom_range(0, 7);
      int idx = $urandom_range(0, 7);
      if ($urandom_range(0, 9) == 0) idle("R11");
      else step(op, idx, {$urandom, $urandom}, reqs[op]);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule